// File: doc/BRIEF.md
# Three-Stage Programmable Line Delay

This block delays an 8-bit sample stream by a programmable number of clock cycles. Three delay lines sit in series. Each line's length is set on its own and can be anything from 0 to 1120 cycles. Samples enter the first line (stage C), pass through stage B and then stage A, and leave from the output of stage A. The chain is used to line up the rows of an image or the taps of a filter with the sample now arriving.

A small register port holds the settings:
- the three length words;
- a static control word with a bypass bit and an output-enable bit.

When bypass is set, the input skips all three lines and reaches the output through a fixed two-register pipe. When output-enable is clear, the output is not driven. The pad tristate is modelled here as a drive flag plus a data bus held at zero.

The stream has no back-pressure. A sample is taken on every clock, so the input has no ready and no valid. The drive flag is the only qualifier on the output. After a length change, each line keeps writing its buffer without a break. Its output is the sample that entered it exactly "length" cycles before, so the result is valid again once fresh data has passed through the stages that follow.

Top module: `line_delay_chain`

## Requirements
- R1: A delay line whose length field holds L > 0 presents at its output the sample that entered it L clock cycles earlier.
- R2: A length of 0 makes that stage pass its input to its output in the same cycle, with no register in the path.
- R3: Lengths from 0 to 1120 inclusive are legal, and the largest length, 1120, delays by exactly 1120 cycles.
- R4: Bits [15:11] of each length word always read back as 0. Bits [15:2] of the static word also always read back as 0, whatever was written.
- R5: Samples pass through stage C, then B, then A. With bypass off, the total delay from `din` to `dout` is the sum of the three lengths.
- R6: When static bit 0 (bypass) is 1, `dout` equals the `din` value of two cycles earlier, whatever the lengths are. Clearing the bit returns the output to the chain.
- R7: When static bit 1 (output enable) is 0, `out_drive` is 0 and `dout` is 0. When the bit is 1, `out_drive` is 1.
- R8: After reset, every word reads 0, so bypass is off, the output is disabled and every length is 0.
- R9: After a length change, each line keeps writing one sample per cycle. A line's output is always its input from exactly its current length earlier, including the samples written before the change.
- R10: A write takes effect at the clock edge on which `cfg_we` is 1.
  - Address 0 is the static word. Address 1 is the stage A length, address 2 the stage B length and address 3 the stage C length.
  - `cfg_rdata` shows the word at `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Input sample, taken on every clock |
| dout | output | 8 | Delayed or bypassed sample, 0 while the output is disabled |
| out_drive | output | 1 | High when the output is enabled (models the pad drive) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 static, 1 length A, 2 length B, 3 length C |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Readback of the selected register, reserved bits zero |

## Verification
A write issued in cycle j governs the output from cycle j+1 on. A stage of length L shows the input of cycle j in cycle j+L, or in cycle j itself when L is 0. The bypass path shows the input of cycle j in cycle j+2, and readback and the drive flag follow in the same cycle as the state they reflect. The bench applies inputs just after each rising edge and samples at the falling edge. It keeps a time-indexed history of each stage's input, so the expected output in every cycle is looked up at the exact offset the current lengths imply. Samples that would come from before reset are marked unknown and not compared.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  localparam int NSTAGE = 3;
  localparam int BIT_BYPASS = 0;
  localparam int BIT_DRIVE = 1;

  typedef enum logic [1:0] {
    SEL_STATIC = 2'd0,
    SEL_LEN_A  = 2'd1,
    SEL_LEN_B  = 2'd2,
    SEL_LEN_C  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ldc_ctrl_regs.sv
module ldc_ctrl_regs
  import ldc_pkg::*;
#(
  parameter int LW      = 11,
  parameter int CW      = 16,
  parameter int MAX_LEN = 1120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [LW-1:0] len_a,
  output logic [LW-1:0] len_b,
  output logic [LW-1:0] len_c,
  output logic          bypass,
  output logic          drive
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[CW-1:LW];

  always_ff @(posedge clk) begin
    if (rst) begin
      len_a  <= '0;
      len_b  <= '0;
      len_c  <= '0;
      bypass <= 1'b0;
      drive  <= 1'b0;
    end else if (we) begin
      case (reg_sel_e'(addr))
        SEL_STATIC: begin
          bypass <= wdata[BIT_BYPASS];
          drive  <= wdata[BIT_DRIVE];
        end
        SEL_LEN_A: len_a <= wdata[LW-1:0];
        SEL_LEN_B: len_b <= wdata[LW-1:0];
        default:   len_c <= wdata[LW-1:0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      SEL_STATIC: begin
        rdata[BIT_BYPASS] = bypass;
        rdata[BIT_DRIVE]  = drive;
      end
      SEL_LEN_A: rdata[LW-1:0] = len_a;
      SEL_LEN_B: rdata[LW-1:0] = len_b;
      default:   rdata[LW-1:0] = len_c;
    endcase
  end

  // R10: a write to the stage A length lands on the next edge
  a_r10_len_a_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SEL_LEN_A) |=> len_a == $past(wdata[LW-1:0]));

  // R3: only legal lengths are ever written
  a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
    (we && addr != SEL_STATIC) |-> wdata[LW-1:0] <= LW'(MAX_LEN));

  // R8: every word is cleared by reset
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (len_a == '0 && len_b == '0 && len_c == '0 && !bypass && !drive));
endmodule

// File: rtl/ldc_delay_line.sv
module ldc_delay_line #(
  parameter int DW    = 8,
  parameter int LW    = 11,
  parameter int DEPTH = 1120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = (LW > AW ? LW : AW) + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [PW-1:0] wp_x, ln_x, rd_x;
  logic [AW-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (rst) wptr <= '0;
    else     wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst) mem[wptr] <= din;
  end

  always_comb begin
    wp_x = PW'(wptr);
    ln_x = PW'(len);
    rd_x = (wp_x >= ln_x) ? (wp_x - ln_x) : (wp_x + PW'(DEPTH) - ln_x);
  end

  assign rd_idx = rd_x[AW-1:0];

  logic unused_rd;
  assign unused_rd = ^rd_x[PW-1:AW];

  assign dout = (len == '0) ? din : mem[rd_idx];

  // R9: the write pointer steps once per cycle and wraps at the buffer size
  a_r9_wptr_step: assert property (@(posedge clk) disable iff (rst)
    (wptr == AW'(DEPTH - 1)) |=> wptr == '0);

  a_r9_wptr_inc: assert property (@(posedge clk) disable iff (rst)
    (wptr != AW'(DEPTH - 1)) |=> wptr == $past(wptr) + 1'b1);
endmodule

// File: rtl/ldc_bypass_pipe.sv
module ldc_bypass_pipe #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] pipe [STAGES+1];
  assign pipe[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) pipe[g+1] <= '0;
      else     pipe[g+1] <= pipe[g];
    end
  end

  assign dout = pipe[STAGES];
endmodule

// File: rtl/line_delay_chain.sv
module line_delay_chain
  import ldc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LW      = 11,
  parameter int CW      = 16,
  parameter int MAX_LEN = 1120,
  parameter int BYP_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          out_drive,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata
);
  logic [LW-1:0] len_a, len_b, len_c;
  logic          bypass, drive;
  logic [LW-1:0] stage_len [NSTAGE];
  logic [DW-1:0] chain [NSTAGE+1];
  logic [DW-1:0] byp_q, sel_data;

  ldc_ctrl_regs #(.LW(LW), .CW(CW), .MAX_LEN(MAX_LEN)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .len_a(len_a), .len_b(len_b), .len_c(len_c),
    .bypass(bypass), .drive(drive)
  );

  // stage 0 is C, stage 1 is B, stage 2 is A
  assign stage_len[0] = len_c;
  assign stage_len[1] = len_b;
  assign stage_len[2] = len_a;
  assign chain[0]     = din;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    ldc_delay_line #(.DW(DW), .LW(LW), .DEPTH(MAX_LEN)) u_line (
      .clk(clk), .rst(rst), .len(stage_len[g]),
      .din(chain[g]), .dout(chain[g+1])
    );
  end

  ldc_bypass_pipe #(.DW(DW), .STAGES(BYP_LAT)) u_byp (
    .clk(clk), .rst(rst), .din(din), .dout(byp_q)
  );

  assign sel_data  = bypass ? byp_q : chain[NSTAGE];
  assign dout      = drive ? sel_data : '0;
  assign out_drive = drive;

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 2'd2) warm <= warm + 1'b1;
  end

  // R6: bypass output is the input of two cycles earlier
  a_r6_bypass_lat: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && bypass && drive && BYP_LAT == 2) |-> dout == $past(din, 2));

  // R7: a disabled output carries no data
  a_r7_quiet_off: assert property (@(posedge clk) disable iff (rst)
    !out_drive |-> dout == '0);
endmodule

// File: tb/test_line_delay_chain.sv
module test_line_delay_chain;
  localparam int HMAX = 16384;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        out_drive;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  line_delay_chain i_line_delay_chain (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .out_drive(out_drive),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int k = 0;
  int hist [3][HMAX];
  int sh_len [3];
  bit sh_byp = 0;
  bit sh_drv = 0;
  string phase = "R8";
  logic [15:0] last_rd;
  logic [7:0]  last_out;
  logic        last_drv;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int stage_out(input int s, input int x_now);
    int l;
    l = sh_len[s];
    if (l == 0) return x_now;
    if (k - l < 0) return -1;
    return hist[s][k-l];
  endfunction

  task automatic model_step();
    int xc, xb, xa, e;
    xc = stage_out(0, int'(din));
    xb = stage_out(1, xc);
    xa = stage_out(2, xb);
    if (sh_byp) e = (k >= 2) ? hist[0][k-2] : 0;
    else        e = xa;
    if (!sh_drv) e = 0;
    chk(out_drive == sh_drv, {phase, " drive"}, int'(out_drive), int'(sh_drv));
    if (e >= 0) chk(int'(dout) == e, {phase, " dout"}, int'(dout), e);
    hist[0][k] = int'(din);
    hist[1][k] = xc;
    hist[2][k] = xb;
    k++;
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin sh_byp = cfg_wdata[0]; sh_drv = cfg_wdata[1]; end
        2'd1: sh_len[2] = int'(cfg_wdata[10:0]);
        2'd2: sh_len[1] = int'(cfg_wdata[10:0]);
        default: sh_len[0] = int'(cfg_wdata[10:0]);
      endcase
    end
  endtask

  task automatic tick(input logic [7:0] d, input logic we, input logic [1:0] a, input logic [15:0] wd);
    @(posedge clk);
    #1;
    din = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(negedge clk);
    last_rd = cfg_rdata;
    last_out = dout;
    last_drv = out_drive;
    if (!rst) model_step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] wd);
    tick(8'($urandom), 1'b1, a, wd);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(8'($urandom), 1'b0, 2'd0, 16'h0);
  endtask

  task automatic rd(input logic [1:0] a);
    tick(8'($urandom), 1'b0, a, 16'h0);
  endtask

  initial begin
    // R8: reset state, observed at the ports while reset is held
    tick(8'h00, 1'b0, 2'd0, 16'h0);
    tick(8'h00, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'h00 && last_drv == 1'b0, "R8 reset output", int'(last_out), 0);
    @(posedge clk); #1; rst = 1'b0;
    k = 0;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      chk(last_rd == 16'h0, "R8 reset readback", int'(last_rd), 0);
    end

    // R4 / R10: reserved bits read zero
    phase = "R4";
    wr(2'd0, 16'hFFFE);
    rd(2'd0);
    chk(last_rd == 16'h0002, "R4 static readback", int'(last_rd), 2);
    chk(last_drv == 1'b1, "R7 drive on", int'(last_drv), 1);
    wr(2'd3, 16'hF803);
    rd(2'd3);
    chk(last_rd == 16'h0003, "R4 len C readback", int'(last_rd), 3);
    wr(2'd2, 16'h0005);
    wr(2'd1, 16'h8007);
    rd(2'd1);
    chk(last_rd == 16'h0007, "R10 len A readback", int'(last_rd), 7);

    // R1 R5: chain of 3+5+7
    phase = "R5";
    run(80);

    // R1: single stage of two, explicit
    phase = "R1";
    wr(2'd3, 16'd2); wr(2'd2, 16'd0); wr(2'd1, 16'd0);
    run(5);
    tick(8'h11, 1'b0, 2'd0, 16'h0);
    tick(8'h22, 1'b0, 2'd0, 16'h0);
    tick(8'h33, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'h11, "R1 delay two", int'(last_out), 'h11);

    // R5: one cycle in each stage gives three
    phase = "R5";
    wr(2'd3, 16'd1); wr(2'd2, 16'd1); wr(2'd1, 16'd1);
    run(5);
    tick(8'hA1, 1'b0, 2'd0, 16'h0);
    run(2);
    tick(8'h00, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'hA1, "R5 sum of lengths", int'(last_out), 'hA1);

    // R9: length change mid-stream, history preserved
    phase = "R9";
    wr(2'd2, 16'd9);
    run(30);
    wr(2'd3, 16'd0);
    run(30);

    // R2: all lengths zero pass through in the same cycle
    phase = "R2";
    wr(2'd2, 16'd0); wr(2'd1, 16'd0);
    run(2);
    tick(8'h5A, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'h5A, "R2 same cycle", int'(last_out), 'h5A);

    // R3: largest length
    phase = "R3";
    wr(2'd3, 16'd1120);
    wr(2'd1, 16'd0);
    tick(8'hC3, 1'b0, 2'd0, 16'h0);
    run(1119);
    tick(8'h00, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'hC3, "R3 max length", int'(last_out), 'hC3);
    run(20);

    // R6: bypass
    phase = "R6";
    wr(2'd0, 16'h0003);
    run(10);
    tick(8'h77, 1'b0, 2'd0, 16'h0);
    tick(8'h88, 1'b0, 2'd0, 16'h0);
    tick(8'h99, 1'b0, 2'd0, 16'h0);
    chk(last_out == 8'h77, "R6 two cycle bypass", int'(last_out), 'h77);
    run(30);
    wr(2'd0, 16'h0002);
    run(40);

    // R7: output disabled
    phase = "R7";
    wr(2'd0, 16'h0000);
    run(5);
    chk(last_out == 8'h00 && last_drv == 1'b0, "R7 disabled", int'(last_out), 0);
    run(15);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", WD_CYCLES, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule